// File: doc/BRIEF.md
# VGA planar write datapath

This block converts a single byte written by the host into display memory into one 32-bit word spanning four 8-bit colour planes, as the graphics controller of a legacy VGA does. The host byte is first rotated, then expanded into four plane bytes by one of four write modes. The expanded word is combined with the 32-bit display latch by a two-operand raster-op unit. A per-bit mask then chooses, for each bit position, the raster-op result or the latch.

The caller supplies the host byte, the latch contents captured by the last read, and the controller's register fields with each write. The block returns the word to store and a byte strobe per plane. The result is registered and appears one clock after the write-valid input, together with an output valid. Address generation, the memory and the read path lie outside the block.

Top module: `vgaw_write_path`

## Requirements
- R1: The host byte is rotated right by `rot_cnt_i` (0..7) positions before the write-mode logic. With mode 0, no set/reset enables, COPY and mask 8'hFF, every plane byte equals the rotated byte.
- R2: In mode 0 (`wmode_i`=2'd0), plane byte b (bits 8b+7..8b) is filled with `setres_i[b]` when `setres_en_i[b]`=1 and with the rotated host byte otherwise.
- R3: In mode 1 (`wmode_i`=2'd1), the output word equals the display latch. The host byte, ALU function and bit mask have no effect.
- R4: In mode 2 (`wmode_i`=2'd2), all eight bits of plane byte b take the unrotated host bit b, for b in 0..3. The rotate count has no effect.
- R5: In mode 3 (`wmode_i`=2'd3), all bits of plane byte b take `setres_i[b]`, and the effective mask is the rotated host byte ANDed with `bitmask_i`.
- R6: The ALU takes the write-mode word and the latch. `alu_op_i` 2'b00 is COPY (write-mode word), 2'b01 is AND, 2'b10 is OR and 2'b11 is XOR.
- R7: Outside mode 1, mask bit n selects bit n of all four plane bytes: 1 takes the ALU result and 0 takes the latch. A zero mask returns the latch.
- R8: On a write, `wstrb_o[b]` equals `plane_en_i[b]`, which enables plane byte b.
- R9: `wdata_o`, `wstrb_o` and `wvalid_o` change one clock after a cycle with `wr_valid_i`=1, and `wvalid_o` is 1 in that cycle. A cycle without a write gives `wvalid_o`=0 and `wstrb_o`=0 on the next clock, and `wdata_o` keeps its value.
- R10: While `rst_n` is low, `wdata_o`, `wstrb_o` and `wvalid_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Host write present this cycle |
| host_byte_i | input | 8 | Byte written by the host |
| latch_i | input | 32 | Display latch, plane b in bits 8b+7..8b |
| rot_cnt_i | input | 3 | Right-rotate amount |
| wmode_i | input | 2 | Write mode 0..3 |
| setres_i | input | 4 | Set/reset value per plane |
| setres_en_i | input | 4 | Set/reset enable per plane (mode 0) |
| alu_op_i | input | 2 | 00 COPY, 01 AND, 10 OR, 11 XOR |
| bitmask_i | input | 8 | Latch/ALU select per bit position |
| plane_en_i | input | 4 | Plane write enables |
| wdata_o | output | 32 | Word to store |
| wstrb_o | output | 4 | Per-plane byte strobes |
| wvalid_o | output | 1 | Output word valid |

## Verification
Each write is independent and passes through one register stage. A wrong mode selection, rotate or mask therefore corrupts `wdata_o` in the very next cycle, and only in the affected plane bytes or bit columns. Mixing distinct latch and host patterns in every mode means a swapped plane, a wrong rotate direction or an inverted mask select shows up as a miscompare of the single word written. A wrong valid or strobe register shows up as a missing strobe or a stale `wvalid_o` one clock after the write or the idle cycle.

// File: rtl/vgaw_pkg.sv
package vgaw_pkg;
    localparam logic [1:0] WMODE_MIX    = 2'd0;
    localparam logic [1:0] WMODE_LATCH  = 2'd1;
    localparam logic [1:0] WMODE_FILL   = 2'd2;
    localparam logic [1:0] WMODE_SRMASK = 2'd3;

    localparam logic [1:0] ROP_COPY = 2'b00;
    localparam logic [1:0] ROP_AND  = 2'b01;
    localparam logic [1:0] ROP_OR   = 2'b10;
    localparam logic [1:0] ROP_XOR  = 2'b11;
endpackage

// File: rtl/vgaw_rotator.sv
module vgaw_rotator #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] cnt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl  = {din, din} >> cnt;
        dout = dbl[W-1:0];
    end
endmodule

// File: rtl/vgaw_mode_unit.sv
module vgaw_mode_unit
    import vgaw_pkg::*;
#(
    parameter int PLANES  = 4,
    parameter int PLANE_W = 8,
    localparam int WORD_W = PLANES * PLANE_W
) (
    input  logic [1:0]         wmode,
    input  logic [PLANE_W-1:0] rot_byte,
    input  logic [PLANES-1:0]  host_lo,
    input  logic [PLANES-1:0]  setres,
    input  logic [PLANES-1:0]  setres_en,
    input  logic [PLANE_W-1:0] bitmask,
    output logic [WORD_W-1:0]  mode_word,
    output logic [PLANE_W-1:0] eff_mask
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [PLANE_W-1:0] pb;
        always_comb begin
            case (wmode)
                WMODE_MIX:  pb = setres_en[p] ? {PLANE_W{setres[p]}} : rot_byte;
                WMODE_FILL: pb = {PLANE_W{host_lo[p]}};
                default:    pb = {PLANE_W{setres[p]}};
            endcase
        end
        assign mode_word[p*PLANE_W +: PLANE_W] = pb;
    end

    assign eff_mask = (wmode == WMODE_SRMASK) ? (rot_byte & bitmask) : bitmask;
endmodule

// File: rtl/vgaw_rop_unit.sv
module vgaw_rop_unit
    import vgaw_pkg::*;
#(
    parameter int PLANES  = 4,
    parameter int PLANE_W = 8,
    localparam int WORD_W = PLANES * PLANE_W
) (
    input  logic [WORD_W-1:0]  mode_word,
    input  logic [WORD_W-1:0]  latch,
    input  logic [1:0]         alu_op,
    input  logic [PLANE_W-1:0] eff_mask,
    input  logic               bypass,
    output logic [WORD_W-1:0]  out_word
);
    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        logic [PLANE_W-1:0] a, l, r;
        assign a = mode_word[p*PLANE_W +: PLANE_W];
        assign l = latch[p*PLANE_W +: PLANE_W];
        always_comb begin
            case (alu_op)
                ROP_AND: r = a & l;
                ROP_OR:  r = a | l;
                ROP_XOR: r = a ^ l;
                default: r = a;
            endcase
        end
        assign out_word[p*PLANE_W +: PLANE_W] =
            bypass ? l : ((r & eff_mask) | (l & ~eff_mask));
    end
endmodule

// File: rtl/vgaw_write_path.sv
module vgaw_write_path
    import vgaw_pkg::*;
#(
    parameter int PLANES  = 4,
    parameter int PLANE_W = 8,
    localparam int WORD_W = PLANES * PLANE_W,
    localparam int CW     = $clog2(PLANE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid_i,
    input  logic [PLANE_W-1:0] host_byte_i,
    input  logic [WORD_W-1:0]  latch_i,
    input  logic [CW-1:0]      rot_cnt_i,
    input  logic [1:0]         wmode_i,
    input  logic [PLANES-1:0]  setres_i,
    input  logic [PLANES-1:0]  setres_en_i,
    input  logic [1:0]         alu_op_i,
    input  logic [PLANE_W-1:0] bitmask_i,
    input  logic [PLANES-1:0]  plane_en_i,
    output logic [WORD_W-1:0]  wdata_o,
    output logic [PLANES-1:0]  wstrb_o,
    output logic               wvalid_o
);
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [PLANES-1:0] strb;
        logic              valid;
    } out_t;

    out_t st_d, st_q;

    logic [PLANE_W-1:0] rot_byte;
    logic [WORD_W-1:0]  mode_word;
    logic [PLANE_W-1:0] eff_mask;
    logic [WORD_W-1:0]  rop_word;

    vgaw_rotator #(.W(PLANE_W)) u_rot (
        .din  (host_byte_i),
        .cnt  (rot_cnt_i),
        .dout (rot_byte)
    );

    vgaw_mode_unit #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_mode (
        .wmode     (wmode_i),
        .rot_byte  (rot_byte),
        .host_lo   (host_byte_i[PLANES-1:0]),
        .setres    (setres_i),
        .setres_en (setres_en_i),
        .bitmask   (bitmask_i),
        .mode_word (mode_word),
        .eff_mask  (eff_mask)
    );

    vgaw_rop_unit #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_rop (
        .mode_word (mode_word),
        .latch     (latch_i),
        .alu_op    (alu_op_i),
        .eff_mask  (eff_mask),
        .bypass    (wmode_i == WMODE_LATCH),
        .out_word  (rop_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = wr_valid_i;
        st_d.strb  = wr_valid_i ? plane_en_i : '0;
        if (wr_valid_i) begin
            st_d.data = rop_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wdata_o  = st_q.data;
    assign wstrb_o  = st_q.strb;
    assign wvalid_o = st_q.valid;
endmodule

// File: rtl/vgaw_write_path_chk.sv
module vgaw_write_path_chk #(
    parameter int PLANES  = 4,
    parameter int PLANE_W = 8,
    localparam int WORD_W = PLANES * PLANE_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_valid_i,
    input logic [WORD_W-1:0]  latch_i,
    input logic [1:0]         wmode_i,
    input logic [PLANE_W-1:0] bitmask_i,
    input logic [PLANES-1:0]  plane_en_i,
    input logic [WORD_W-1:0]  wdata_o,
    input logic [PLANES-1:0]  wstrb_o,
    input logic               wvalid_o
);
    AST_VALID_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |=> wvalid_o); // R9
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> (!wvalid_o && wstrb_o == '0)); // R9
    AST_DATA_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> $stable(wdata_o)); // R9
    AST_STRB_FROM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |=> wstrb_o == $past(plane_en_i)); // R8
    AST_LATCH_MODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wmode_i == 2'd1) |=> wdata_o == $past(latch_i)); // R3
    AST_ZERO_MASK_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && bitmask_i == '0) |=> wdata_o == $past(latch_i)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (wdata_o == '0 && wstrb_o == '0 && !wvalid_o)); // R10
endmodule

bind vgaw_write_path vgaw_write_path_chk #(.PLANES(PLANES), .PLANE_W(PLANE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid_i),
    .latch_i    (latch_i),
    .wmode_i    (wmode_i),
    .bitmask_i  (bitmask_i),
    .plane_en_i (plane_en_i),
    .wdata_o    (wdata_o),
    .wstrb_o    (wstrb_o),
    .wvalid_o   (wvalid_o)
);

// File: tb/tb_vgaw_write_path.sv
`timescale 1ns/1ps
module tb_vgaw_write_path;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [7:0]  host_byte_i = '0;
    logic [31:0] latch_i = '0;
    logic [2:0]  rot_cnt_i = '0;
    logic [1:0]  wmode_i = '0;
    logic [3:0]  setres_i = '0;
    logic [3:0]  setres_en_i = '0;
    logic [1:0]  alu_op_i = '0;
    logic [7:0]  bitmask_i = '0;
    logic [3:0]  plane_en_i = '0;
    logic [31:0] wdata_o;
    logic [3:0]  wstrb_o;
    logic        wvalid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vgaw_write_path dut (.*);

    typedef struct packed {
        logic [7:0]  host;
        logic [2:0]  rot;
        logic [1:0]  mode;
        logic [3:0]  sr;
        logic [3:0]  sre;
        logic [1:0]  alu;
        logic [7:0]  mask;
        logic [3:0]  pen;
        logic [31:0] latch;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h81, 3'd1, 2'd0, 4'h0, 4'h0, 2'b00, 8'hFF, 4'hF, 32'h00000000, 4'd1},
        '{8'h96, 3'd7, 2'd0, 4'h0, 4'h0, 2'b00, 8'hFF, 4'hF, 32'h11111111, 4'd1},
        '{8'h3C, 3'd3, 2'd0, 4'h5, 4'h6, 2'b00, 8'hFF, 4'hF, 32'hA5A5A5A5, 4'd2},
        '{8'h55, 3'd2, 2'd1, 4'hF, 4'hF, 2'b11, 8'h00, 4'hF, 32'h12345678, 4'd3},
        '{8'h0A, 3'd5, 2'd2, 4'h0, 4'h0, 2'b00, 8'hFF, 4'hF, 32'hFFFF0000, 4'd4},
        '{8'hE1, 3'd4, 2'd3, 4'hA, 4'h0, 2'b00, 8'h3C, 4'hF, 32'h00000000, 4'd5},
        '{8'h3C, 3'd0, 2'd0, 4'h0, 4'h0, 2'b01, 8'hFF, 4'hF, 32'h0F0F0F0F, 4'd6},
        '{8'hC3, 3'd0, 2'd0, 4'h0, 4'h0, 2'b10, 8'hFF, 4'hF, 32'h12345678, 4'd6},
        '{8'h00, 3'd0, 2'd0, 4'hF, 4'hF, 2'b11, 8'hFF, 4'hF, 32'h0F0F0F0F, 4'd6},
        '{8'h0F, 3'd0, 2'd2, 4'h0, 4'h0, 2'b10, 8'h5A, 4'h3, 32'hDEADBEEF, 4'd7},
        '{8'h77, 3'd6, 2'd0, 4'h5, 4'hF, 2'b00, 8'h00, 4'h9, 32'h13572468, 4'd7},
        '{8'hFF, 3'd0, 2'd3, 4'hF, 4'h0, 2'b01, 8'hFF, 4'h6, 32'hCAFEF00D, 4'd8}
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Reference written from the requirements, bit by bit
    function automatic logic [31:0] model(input vec_t v);
        logic [7:0]  r, m;
        logic [31:0] res;
        logic        wm, al, lt;
        r = v.host;
        for (int i = 0; i < int'(v.rot); i++) r = {r[0], r[7:1]};
        m = (v.mode == 2'd3) ? (r & v.mask) : v.mask;
        for (int b = 0; b < 4; b++) begin
            for (int n = 0; n < 8; n++) begin
                lt = v.latch[8*b+n];
                case (v.mode)
                    2'd0: wm = v.sre[b] ? v.sr[b] : r[n];
                    2'd2: wm = v.host[b];
                    default: wm = v.sr[b];
                endcase
                case (v.alu)
                    2'b01: al = wm & lt;
                    2'b10: al = wm | lt;
                    2'b11: al = wm ^ lt;
                    default: al = wm;
                endcase
                res[8*b+n] = (v.mode == 2'd1) ? lt : (m[n] ? al : lt);
            end
        end
        return res;
    endfunction

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        host_byte_i = v.host;  rot_cnt_i = v.rot;  wmode_i = v.mode;
        setres_i = v.sr;       setres_en_i = v.sre; alu_op_i = v.alu;
        bitmask_i = v.mask;    plane_en_i = v.pen;  latch_i = v.latch;
        wr_valid_i = 1'b1;
    endtask

    task automatic one_write(input vec_t v, input logic [31:0] exp);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        wr_valid_i = 1'b0;
        chk({tag(v.req), " data"}, wdata_o, exp);
    endtask

    function automatic vec_t mk(input logic [7:0] h, input logic [2:0] rc, input logic [1:0] md,
                                input logic [3:0] sr, input logic [3:0] sre, input logic [1:0] al,
                                input logic [7:0] mk_, input logic [31:0] lt);
        vec_t v;
        v = '{h, rc, md, sr, sre, al, mk_, 4'hF, lt, 4'd1};
        return v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        vec_t a, b;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 data", wdata_o, 32'h0);
        chk("R10 strb", {28'h0, wstrb_o}, 32'h0);
        chk("R10 valid", {31'h0, wvalid_o}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            wr_valid_i = 1'b0;
            chk({tag(VECS[i].req), " data"}, wdata_o, model(VECS[i]));
            chk("R8 strb", {28'h0, wstrb_o}, {28'h0, VECS[i].pen});
            chk("R9 valid", {31'h0, wvalid_o}, 32'h1);
        end

        // R9: idle cycle clears valid and strobes, holds data
        @(negedge clk);
        chk("R9 idle valid", {31'h0, wvalid_o}, 32'h0);
        chk("R9 idle strb", {28'h0, wstrb_o}, 32'h0);
        chk("R9 idle hold", wdata_o, model(VECS[NV-1]));

        // Hand-computed corner cases
        one_write(mk(8'h81, 3'd1, 2'd0, 4'h0, 4'h0, 2'b00, 8'hFF, 32'h0), 32'hC0C0C0C0);      // R1
        one_write(mk(8'h05, 3'd3, 2'd2, 4'h0, 4'h0, 2'b00, 8'hFF, 32'h0), 32'h00FF00FF);      // R4
        one_write(mk(8'hAA, 3'd2, 2'd1, 4'h0, 4'h0, 2'b11, 8'h0F, 32'h12345678), 32'h12345678); // R3
        one_write(mk(8'hF0, 3'd0, 2'd3, 4'hA, 4'h0, 2'b00, 8'h3C, 32'h0), 32'h30003000);      // R5
        one_write(mk(8'h00, 3'd0, 2'd0, 4'hF, 4'hF, 2'b11, 8'hFF, 32'h0F0F0F0F), 32'hF0F0F0F0); // R6
        one_write(mk(8'hFF, 3'd0, 2'd0, 4'h0, 4'h0, 2'b00, 8'h00, 32'h89ABCDEF), 32'h89ABCDEF); // R7
        one_write(mk(8'h3C, 3'd0, 2'd0, 4'h0, 4'h0, 2'b01, 8'hFF, 32'h0F0F0F0F), 32'h0C0C0C0C); // R6 AND
        one_write(mk(8'h01, 3'd0, 2'd0, 4'h5, 4'h5, 2'b00, 8'hFF, 32'h0), 32'h01FF01FF);      // R2

        // R9: back-to-back writes each land one clock later
        a = mk(8'h81, 3'd0, 2'd0, 4'h0, 4'h0, 2'b00, 8'hFF, 32'h0);
        b = mk(8'h00, 3'd0, 2'd1, 4'h0, 4'h0, 2'b00, 8'hFF, 32'h55AA55AA);
        @(negedge clk);
        drive(a);
        @(negedge clk);
        drive(b);
        chk("R9 first of pair", wdata_o, 32'h81818181);
        @(negedge clk);
        wr_valid_i = 1'b0;
        chk("R9 second of pair", wdata_o, 32'h55AA55AA);
        chk("R9 pair valid", {31'h0, wvalid_o}, 32'h1);

        // R10: reset mid-run clears outputs
        @(negedge clk);
        drive(a);
        rst_n = 1'b0;
        @(negedge clk);
        wr_valid_i = 1'b0;
        chk("R10 reset data", wdata_o, 32'h0);
        chk("R10 reset valid", {31'h0, wvalid_o}, 32'h0);
        rst_n = 1'b1;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule